// File: doc/BRIEF.md
# NAND Flash Operation Sequencer

This block runs one raw NAND bus transaction at a time. Software first loads the opcodes, the address bytes, a byte count and a strobe timing word through a small register port. It then writes an operation word. The operation word selects which of six fixed bus phases take part, which chip is addressed and how many address bytes go out. The engine drives the command-latch, address-latch, write-strobe, read-strobe and chip-enable lines and an 8-bit data bus, all from registers. It watches the device ready/busy line through a two-flop synchronizer.

Bytes taken in during the read phase land in a small local buffer. The same buffer supplies the bytes for the write phase. Software reaches it through a window in the register map. A single status bit tells software when the engine is idle again. Typical uses are ID reads, status reads, block erase and short program sequences.

Top module: `nand_op_seq`

## Requirements
- R1: After reset all chip enables are high (inactive), both strobes are high, the command and address latches are low, the status bit reads 1, and the timing register reads 0x375.
- R2: Enabled phases run in the fixed order first command, address, write data, second command, wait-ready, read data. A disabled phase, an address phase with zero cycles and a data phase with a zero count are all skipped, and an operation with no phases completes with no bus activity.
- R3: Register word indices: 0 opcodes (first opcode in bits 7:0, second in bits 15:8), 1 address low word, 2 address high word, 3 byte count, 4 timing, 5 operation, 6 status, 16+i buffer byte i. Operation word bits: 1 read data, 2 wait ready, 3 second command, 4 write data, 5 address, 6 first command, 8:7 chip select, 11:9 address-cycle count. Register reads return data one cycle after the address is presented.
- R4: The address phase sends exactly as many bytes as the address-cycle field, least significant first: low-word bytes 0 to 3, then high-word byte 0 and upward. The address latch is high only in this phase.
- R5: Timing word: write-strobe low time in bits 3:0, read-strobe low time in bits 7:4, shared strobe high time in bits 11:8, all in clock cycles, with 0 treated as 1. Consecutive strobes are separated by exactly the high time.
- R6: The read phase captures the number of bytes in the count register (at most the buffer depth) into buffer bytes 0 upward, sampling the bus in the last low cycle of each read strobe.
- R7: The write phase drives buffer bytes 0 upward onto the bus, one per write strobe, for the count register's number of bytes.
- R8: The wait-ready phase lasts at least a guard time and then holds until the synchronized ready/busy input is high. The engine goes idle three cycles after that input rises.
- R9: Status bit 0 is 0 from the cycle after an operation is accepted until it finishes, and 1 otherwise.
- R10: A write to the operation register or to the buffer while an operation runs is ignored: the running operation is unchanged and nothing is queued.
- R11: During an operation only the chip enable picked by the chip-select field is low. All are high when idle.
- R12: The command latch is high only in command phases, never together with the address latch, and the two strobes are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after reg_addr |
| nand_rb_n | input | 1 | Device ready (1) / busy (0) |
| nand_io_in | input | 8 | Data bus from the device |
| nand_io_out | output | 8 | Data bus to the device |
| nand_io_oe | output | 1 | Output enable for nand_io_out |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_ce_n | output | CHIPS | Chip enables, active low |

## Verification
An operation word is accepted at the clock edge that captures it, and a status read issued after that edge already shows 0. Every register read is compared one cycle after its address was driven. Bus outputs are registered, so the bench model samples them on falling clock edges. It measures each strobe's low and high times in whole cycles and logs the latches and data byte at each rising strobe. Ready release is timed against the return of the chip enables, which must come exactly three cycles later: two synchronizer stages plus the output register.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  typedef enum logic [2:0] {
    P_CMD1  = 3'd0,
    P_ADDR  = 3'd1,
    P_WDATA = 3'd2,
    P_CMD2  = 3'd3,
    P_WAIT  = 3'd4,
    P_RDATA = 3'd5,
    P_DONE  = 3'd6,
    P_IDLE  = 3'd7
  } phase_t;

  localparam logic [4:0] RG_CMD    = 5'd0;
  localparam logic [4:0] RG_ADRLO  = 5'd1;
  localparam logic [4:0] RG_ADRHI  = 5'd2;
  localparam logic [4:0] RG_COUNT  = 5'd3;
  localparam logic [4:0] RG_TIMING = 5'd4;
  localparam logic [4:0] RG_OP     = 5'd5;
  localparam logic [4:0] RG_STATUS = 5'd6;

  localparam logic [11:0] TIMING_RST = 12'h375;

endpackage

// File: rtl/nand_seq_sync.sv
module nand_seq_sync (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= 1'b1;
      q    <= 1'b1;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/nand_seq_buf.sv
module nand_seq_buf #(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] ra_addr,
  output logic [7:0]    ra_data,
  input  logic [AW-1:0] rb_addr,
  output logic [7:0]    rb_data
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    ra_data <= mem[ra_addr];
    rb_data <= mem[rb_addr];
  end
endmodule

// File: rtl/nand_seq_engine.sv
module nand_seq_engine
  import nand_seq_pkg::*;
#(
  parameter int BUF_DEPTH = 16,
  parameter int CHIPS     = 4,
  parameter int GUARD     = 4,
  parameter int CW        = $clog2(BUF_DEPTH + 1),
  parameter int AW        = $clog2(BUF_DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [11:0]      op_in,
  input  logic [15:0]      cmd,
  input  logic [63:0]      addr,
  input  logic [CW-1:0]    count,
  input  logic [11:0]      timing,
  input  logic             rb_ready,
  input  logic [7:0]       io_in,
  input  logic [7:0]       buf_rdata,
  output logic [AW-1:0]    buf_raddr,
  output logic             cap_we,
  output logic [AW-1:0]    cap_addr,
  output logic [7:0]       cap_data,
  output logic             idle,
  output logic             cle,
  output logic             ale,
  output logic             we_n,
  output logic             re_n,
  output logic [7:0]       io_out,
  output logic             io_oe,
  output logic [CHIPS-1:0] ce_n
);
  localparam int TW = ($clog2(GUARD + 1) > 4) ? $clog2(GUARD + 1) : 4;

  phase_t          ph_q, ph_n;
  logic            low_q, low_n;
  logic [TW-1:0]   t_q, t_n;
  logic [CW-1:0]   b_q, b_n, last_c;
  logic [1:0]      cs_q, cs_n;
  logic [11:0]     op_q, op_sel;
  logic [5:0]      en;
  logic            take, enter, cap, wsel_q;
  logic [7:0]      io_q, byte_n;

  function automatic logic [TW-1:0] ld(input logic [3:0] x);
    return (x == 4'd0) ? '0 : TW'(x - 4'd1);
  endfunction

  function automatic phase_t first_from(input logic [2:0] s, input logic [5:0] e);
    phase_t r;
    r = P_DONE;
    for (int i = 5; i >= 0; i--)
      if (e[i] && (i >= int'(s))) r = phase_t'(3'(i));
    return r;
  endfunction

  function automatic logic is_wr(input phase_t p);
    return (p == P_CMD1) || (p == P_ADDR) || (p == P_WDATA) || (p == P_CMD2);
  endfunction

  assign take   = start && (ph_q == P_IDLE);
  assign op_sel = take ? op_in : op_q;
  assign en = {op_sel[1] && (count != '0), op_sel[2], op_sel[3],
               op_sel[4] && (count != '0), op_sel[5] && (op_sel[11:9] != 3'd0),
               op_sel[6]};

  always_comb begin
    case (ph_q)
      P_CMD1, P_CMD2: last_c = CW'(1);
      P_ADDR:         last_c = CW'(op_q[11:9]);
      default:        last_c = count;
    endcase
  end

  always_comb begin
    ph_n  = ph_q;
    low_n = low_q;
    t_n   = t_q;
    b_n   = b_q;
    cs_n  = cs_q;
    enter = 1'b0;
    cap   = 1'b0;
    case (ph_q)
      P_IDLE: if (take) begin
        cs_n  = op_in[8:7];
        ph_n  = first_from(3'd0, en);
        enter = 1'b1;
      end
      P_DONE: ph_n = P_IDLE;
      P_WAIT: begin
        if (t_q != '0) t_n = t_q - 1'b1;
        else if (rb_ready) begin
          ph_n  = first_from(3'd5, en);
          enter = 1'b1;
        end
      end
      default: begin
        if (t_q != '0) t_n = t_q - 1'b1;
        else if (low_q) begin
          low_n = 1'b0;
          t_n   = ld(timing[11:8]);
          cap   = (ph_q == P_RDATA);
        end else if (b_q == last_c - 1'b1) begin
          ph_n  = first_from(3'(ph_q) + 3'd1, en);
          enter = 1'b1;
        end else begin
          b_n   = b_q + 1'b1;
          low_n = 1'b1;
          t_n   = (ph_q == P_RDATA) ? ld(timing[7:4]) : ld(timing[3:0]);
        end
      end
    endcase
    if (enter) begin
      low_n = 1'b1;
      b_n   = '0;
      if (ph_n == P_WAIT)       t_n = TW'(GUARD - 1);
      else if (ph_n == P_RDATA) t_n = ld(timing[7:4]);
      else                      t_n = ld(timing[3:0]);
    end
  end

  always_comb begin
    case (ph_n)
      P_CMD1:  byte_n = cmd[7:0];
      P_CMD2:  byte_n = cmd[15:8];
      P_ADDR:  byte_n = addr[{b_n[2:0], 3'b000} +: 8];
      default: byte_n = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= P_IDLE;
      low_q  <= 1'b0;
      t_q    <= '0;
      b_q    <= '0;
      cs_q   <= '0;
      op_q   <= '0;
      cle    <= 1'b0;
      ale    <= 1'b0;
      we_n   <= 1'b1;
      re_n   <= 1'b1;
      io_q   <= '0;
      io_oe  <= 1'b0;
      wsel_q <= 1'b0;
      ce_n   <= '1;
    end else begin
      ph_q   <= ph_n;
      low_q  <= low_n;
      t_q    <= t_n;
      b_q    <= b_n;
      cs_q   <= cs_n;
      op_q   <= op_sel;
      cle    <= (ph_n == P_CMD1) || (ph_n == P_CMD2);
      ale    <= (ph_n == P_ADDR);
      we_n   <= !(low_n && is_wr(ph_n));
      re_n   <= !(low_n && (ph_n == P_RDATA));
      io_q   <= byte_n;
      io_oe  <= is_wr(ph_n);
      wsel_q <= (ph_n == P_WDATA);
      ce_n   <= ((ph_n == P_IDLE) || (ph_n == P_DONE)) ? '1 : ~(CHIPS'(1) << cs_n);
    end
  end

  assign idle      = (ph_q == P_IDLE);
  assign io_out    = wsel_q ? buf_rdata : io_q;
  assign buf_raddr = b_n[AW-1:0];
  assign cap_we    = cap;
  assign cap_addr  = b_q[AW-1:0];
  assign cap_data  = io_in;

  // R12
  latch_excl_chk: assert property (@(posedge clk) disable iff (rst) !(cle && ale));
  // R12
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst) !(!we_n && !re_n));
  // R11
  ce_single_chk: assert property (@(posedge clk) disable iff (rst) $countones(~ce_n) <= 1);
  // R11
  ce_idle_chk: assert property (@(posedge clk) disable iff (rst) (ph_q == P_IDLE) |-> (&ce_n));
  // R6
  read_no_drive_chk: assert property (@(posedge clk) disable iff (rst) !re_n |-> !io_oe);
  // R8
  wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ph_q == P_WAIT && !rb_ready) |=> (ph_q == P_WAIT));
  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    (ph_q != P_IDLE && start) |=> $stable(cs_q));
endmodule

// File: rtl/nand_op_seq.sv
module nand_op_seq
  import nand_seq_pkg::*;
#(
  parameter int BUF_DEPTH = 16,
  parameter int CHIPS     = 4,
  parameter int GUARD     = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_we,
  input  logic [4:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             nand_rb_n,
  input  logic [7:0]       nand_io_in,
  output logic [7:0]       nand_io_out,
  output logic             nand_io_oe,
  output logic             nand_cle,
  output logic             nand_ale,
  output logic             nand_we_n,
  output logic             nand_re_n,
  output logic [CHIPS-1:0] nand_ce_n
);
  localparam int CW = $clog2(BUF_DEPTH + 1);
  localparam int AW = $clog2(BUF_DEPTH);

  logic [15:0]   cmd_q;
  logic [31:0]   alo_q, ahi_q, rdata_q;
  logic [CW-1:0] cnt_q;
  logic [11:0]   tim_q;
  logic          idle, rb_ready, start, bsel_q;
  logic          cap_we, buf_we;
  logic [AW-1:0] cap_addr, eng_raddr, buf_waddr;
  logic [7:0]    cap_data, buf_wdata, eng_rdata, sw_rdata;

  assign start = reg_we && (reg_addr == RG_OP);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= '0;
      alo_q <= '0;
      ahi_q <= '0;
      cnt_q <= '0;
      tim_q <= TIMING_RST;
    end else if (reg_we && !reg_addr[4]) begin
      case (reg_addr)
        RG_CMD:    cmd_q <= reg_wdata[15:0];
        RG_ADRLO:  alo_q <= reg_wdata;
        RG_ADRHI:  ahi_q <= reg_wdata;
        RG_COUNT:  cnt_q <= (reg_wdata > 32'(BUF_DEPTH)) ? CW'(BUF_DEPTH) : reg_wdata[CW-1:0];
        RG_TIMING: tim_q <= reg_wdata[11:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      bsel_q  <= 1'b0;
    end else begin
      bsel_q <= reg_addr[4];
      case (reg_addr)
        RG_CMD:    rdata_q <= {16'h0, cmd_q};
        RG_ADRLO:  rdata_q <= alo_q;
        RG_ADRHI:  rdata_q <= ahi_q;
        RG_COUNT:  rdata_q <= 32'(cnt_q);
        RG_TIMING: rdata_q <= {20'h0, tim_q};
        RG_STATUS: rdata_q <= {31'h0, idle};
        default:   rdata_q <= '0;
      endcase
    end
  end

  assign reg_rdata = bsel_q ? {24'h0, sw_rdata} : rdata_q;

  assign buf_we    = cap_we || (reg_we && reg_addr[4] && idle);
  assign buf_waddr = cap_we ? cap_addr : reg_addr[AW-1:0];
  assign buf_wdata = cap_we ? cap_data : reg_wdata[7:0];

  nand_seq_sync rb_sync_i (
    .clk (clk),
    .rst (rst),
    .d   (nand_rb_n),
    .q   (rb_ready)
  );

  nand_seq_buf #(.DEPTH(BUF_DEPTH), .AW(AW)) buf_i (
    .clk     (clk),
    .we      (buf_we),
    .waddr   (buf_waddr),
    .wdata   (buf_wdata),
    .ra_addr (eng_raddr),
    .ra_data (eng_rdata),
    .rb_addr (reg_addr[AW-1:0]),
    .rb_data (sw_rdata)
  );

  nand_seq_engine #(
    .BUF_DEPTH (BUF_DEPTH),
    .CHIPS     (CHIPS),
    .GUARD     (GUARD),
    .CW        (CW),
    .AW        (AW)
  ) eng_i (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .op_in     (reg_wdata[11:0]),
    .cmd       (cmd_q),
    .addr      ({ahi_q, alo_q}),
    .count     (cnt_q),
    .timing    (tim_q),
    .rb_ready  (rb_ready),
    .io_in     (nand_io_in),
    .buf_rdata (eng_rdata),
    .buf_raddr (eng_raddr),
    .cap_we    (cap_we),
    .cap_addr  (cap_addr),
    .cap_data  (cap_data),
    .idle      (idle),
    .cle       (nand_cle),
    .ale       (nand_ale),
    .we_n      (nand_we_n),
    .re_n      (nand_re_n),
    .io_out    (nand_io_out),
    .io_oe     (nand_io_oe),
    .ce_n      (nand_ce_n)
  );
endmodule

// File: tb/nand_op_seq_tb_top.sv
`timescale 1ns/1ps
module nand_op_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        nand_rb_n = 1'b1;
  logic [7:0]  nand_io_in = 8'hA0;
  logic [7:0]  nand_io_out;
  logic        nand_io_oe, nand_cle, nand_ale, nand_we_n, nand_re_n;
  logic [3:0]  nand_ce_n;

  always #2.5 clk = ~clk;

  nand_op_seq dut_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .nand_rb_n(nand_rb_n),
    .nand_io_in(nand_io_in), .nand_io_out(nand_io_out), .nand_io_oe(nand_io_oe),
    .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
    .nand_re_n(nand_re_n), .nand_ce_n(nand_ce_n)
  );

  localparam int OP_RD = 1 << 1, OP_WAIT = 1 << 2, OP_CMD2 = 1 << 3;
  localparam int OP_WR = 1 << 4, OP_ADDR = 1 << 5, OP_CMD1 = 1 << 6;

  int errs = 0, checks = 0, cyc = 0;
  bit finished = 1'b0;

  // device model state, written only by the model process
  int ev_n = 0, re_cnt = 0, rd_idx = 0;
  logic [7:0] ev_io [256];
  logic       ev_cle [256], ev_ale [256];
  int         ev_w [256], ev_gap [256];
  logic [3:0] ev_ce [256];
  int         re_w [256];
  logic [3:0] re_ce [256];
  int we_low = 0, we_high = 0, gap_hold = 0, re_low = 0, rb_cnt = 0;
  int rel_cyc = 0, ce_up_cyc = 0;
  logic we_prev = 1'b1, re_prev = 1'b1, ce_all_prev = 1'b1;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!nand_we_n) begin
      if (we_prev) gap_hold = we_high;
      we_low++;
    end else begin
      if (!we_prev && ev_n < 256) begin
        ev_io[ev_n] = nand_io_out; ev_cle[ev_n] = nand_cle; ev_ale[ev_n] = nand_ale;
        ev_w[ev_n] = we_low; ev_gap[ev_n] = gap_hold; ev_ce[ev_n] = nand_ce_n;
        ev_n++;
        we_low = 0; we_high = 0;
        if (nand_cle && nand_io_out == 8'hD0) begin nand_rb_n = 1'b0; rb_cnt = 30; end
      end
      we_high++;
    end
    if (!nand_re_n) re_low++;
    else if (!re_prev && re_cnt < 256) begin
      re_w[re_cnt] = re_low; re_ce[re_cnt] = nand_ce_n;
      re_cnt++; rd_idx++; re_low = 0;
    end
    nand_io_in = 8'hA0 + 8'(rd_idx);
    if (rb_cnt > 0) begin
      rb_cnt--;
      if (rb_cnt == 0) begin nand_rb_n = 1'b1; rel_cyc = cyc; end
    end
    if ((&nand_ce_n) && !ce_all_prev) ce_up_cyc = cyc;
    we_prev = nand_we_n; re_prev = nand_re_n; ce_all_prev = &nand_ce_n;
  end

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [4:0] a, output logic [31:0] v);
    @(negedge clk); reg_addr = a;
    @(negedge clk); v = reg_rdata;
  endtask

  task automatic wait_idle(input string req);
    logic [31:0] v;
    v = 0;
    for (int i = 0; i < 4000 && v[0] == 1'b0; i++) reg_rd(5'd6, v);
    check_eq(req, "engine returns to idle", int'(v[0]), 1);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    @(negedge clk);
    check_eq("R1", "ce_n at reset", int'(nand_ce_n), 'hF);
    check_eq("R1", "strobes at reset", int'({nand_we_n, nand_re_n}), 3);
    check_eq("R1", "latches at reset", int'({nand_cle, nand_ale}), 0);
    reg_rd(5'd6, v);
    check_eq("R9", "status at reset", int'(v[0]), 1);
    reg_rd(5'd4, v);
    check_eq("R5", "timing reset value", int'(v), 'h375);
  endtask

  task automatic t_read_id();
    logic [31:0] v;
    int b, r0;
    b = ev_n; r0 = re_cnt;
    reg_wr(5'd0, 32'h90);
    reg_wr(5'd1, 32'h0);
    reg_wr(5'd3, 32'd5);
    reg_wr(5'd5, OP_CMD1 | OP_ADDR | OP_RD | (1 << 7) | (1 << 9));
    reg_rd(5'd6, v);
    check_eq("R9", "status busy during op", int'(v[0]), 0);
    wait_idle("R9");
    check_eq("R2", "id read strobe count", ev_n - b, 2);
    check_eq("R3", "first opcode byte", int'(ev_io[b]), 'h90);
    check_eq("R12", "cmd latch flags", int'({ev_cle[b], ev_ale[b]}), 2);
    check_eq("R4", "single address byte", int'({ev_ale[b+1], ev_io[b+1]}), 'h100);
    check_eq("R5", "default write low", ev_w[b], 5);
    check_eq("R5", "default write high", ev_gap[b+1], 3);
    check_eq("R11", "chip 1 enable", int'(ev_ce[b]), 'hD);
    check_eq("R6", "read strobe count", re_cnt - r0, 5);
    check_eq("R5", "default read low", re_w[r0], 7);
    check_eq("R11", "chip 1 on reads", int'(re_ce[r0+4]), 'hD);
    for (int i = 0; i < 5; i++) begin
      reg_rd(5'(16 + i), v);
      check_eq("R6", "captured byte", int'(v), int'(8'hA0 + 8'(r0 + i)));
    end
  endtask

  task automatic t_program();
    logic [7:0] exp_io [11];
    logic [1:0] exp_fl [11];
    int b, r0;
    b = ev_n; r0 = re_cnt;
    for (int i = 0; i < 4; i++) reg_wr(5'(16 + i), 32'(8'h5A ^ 8'(i * 'h11)));
    reg_wr(5'd0, 32'h1080);
    reg_wr(5'd1, 32'h44332211);
    reg_wr(5'd2, 32'h55);
    reg_wr(5'd3, 32'd4);
    reg_wr(5'd5, OP_CMD1 | OP_ADDR | OP_WR | OP_CMD2 | (0 << 7) | (5 << 9));
    wait_idle("R2");
    exp_io[0] = 8'h80; exp_fl[0] = 2'b10;
    for (int i = 0; i < 5; i++) begin exp_io[1+i] = 8'h11 * 8'(i + 1); exp_fl[1+i] = 2'b01; end
    for (int i = 0; i < 4; i++) begin exp_io[6+i] = 8'h5A ^ 8'(i * 'h11); exp_fl[6+i] = 2'b00; end
    exp_io[10] = 8'h10; exp_fl[10] = 2'b10;
    check_eq("R2", "program strobe count", ev_n - b, 11);
    for (int i = 0; i < 11; i++) begin
      check_eq(i < 6 ? "R4" : "R7", "program byte", int'(ev_io[b+i]), int'(exp_io[i]));
      check_eq("R2", "program phase flags", int'({ev_cle[b+i], ev_ale[b+i]}), int'(exp_fl[i]));
    end
    check_eq("R11", "chip 0 enable", int'(ev_ce[b+7]), 'hE);
    check_eq("R2", "no reads in program", re_cnt - r0, 0);
  endtask

  task automatic t_erase();
    logic [31:0] v;
    int b;
    b = ev_n;
    reg_wr(5'd4, 32'h132);
    reg_wr(5'd0, 32'hD060);
    reg_wr(5'd1, 32'h00332211);
    reg_wr(5'd5, OP_CMD1 | OP_ADDR | OP_CMD2 | OP_WAIT | (2 << 7) | (3 << 9));
    repeat (20) @(negedge clk);
    reg_rd(5'd6, v);
    check_eq("R8", "busy while device busy", int'(v[0]), 0);
    wait_idle("R8");
    check_eq("R2", "erase strobe count", ev_n - b, 5);
    check_eq("R3", "second opcode byte", int'({ev_cle[b+4], ev_io[b+4]}), 'h1D0);
    check_eq("R4", "third address byte", int'(ev_io[b+3]), 'h33);
    check_eq("R5", "programmed write low", ev_w[b+2], 2);
    check_eq("R5", "programmed high", ev_gap[b+1], 1);
    check_eq("R11", "chip 2 enable", int'(ev_ce[b]), 'hB);
    check_eq("R8", "idle delay after ready", ce_up_cyc - rel_cyc, 3);
  endtask

  task automatic t_zero_timing();
    logic [31:0] v;
    int b, r0;
    b = ev_n; r0 = re_cnt;
    reg_wr(5'd4, 32'h000);
    reg_wr(5'd0, 32'h70);
    reg_wr(5'd3, 32'd1);
    reg_wr(5'd5, OP_CMD1 | OP_RD);
    wait_idle("R5");
    check_eq("R5", "zero write low", ev_w[b], 1);
    check_eq("R5", "zero read low", re_w[r0], 1);
    reg_rd(5'd16, v);
    check_eq("R6", "status byte captured", int'(v), int'(8'hA0 + 8'(r0)));
  endtask

  task automatic t_busy_ignore();
    logic [31:0] v;
    int b, r0;
    b = ev_n; r0 = re_cnt;
    reg_wr(5'd4, 32'hFF0);
    reg_wr(5'd3, 32'd16);
    reg_wr(5'd5, OP_RD);
    repeat (10) @(negedge clk);
    reg_wr(5'd5, OP_CMD1 | (3 << 7));
    reg_wr(5'd31, 32'h00);
    wait_idle("R10");
    check_eq("R10", "no write strobes", ev_n - b, 0);
    check_eq("R10", "full read count", re_cnt - r0, 16);
    check_eq("R10", "chip unchanged", int'(re_ce[r0+15]), 'hE);
    reg_rd(5'd31, v);
    check_eq("R10", "last byte from bus", int'(v), int'(8'hA0 + 8'(r0 + 15)));
    reg_rd(5'd6, v);
    check_eq("R10", "nothing queued", int'(v[0]), 1);
  endtask

  task automatic t_empty();
    int b, r0;
    b = ev_n; r0 = re_cnt;
    reg_wr(5'd3, 32'd0);
    reg_wr(5'd5, OP_RD | OP_ADDR | (1 << 7));
    wait_idle("R2");
    check_eq("R2", "skipped phases emit nothing", (ev_n - b) + (re_cnt - r0), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errs++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_read_id();
    t_program();
    t_erase();
    t_zero_timing();
    t_busy_ignore();
    t_empty();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule